// File: doc/BRIEF.md
# Pseudo-Channel Request Admission Router

This block sits between a single upstream request port and two pseudo-channel request queues of a stacked-memory controller. Each read or write request carries a byte address and a byte size. One address bit chooses the pseudo-channel. The block works out how many memory bursts the request covers and compares that count with the room left in the chosen channel's queue for that direction. An admitted request is pushed to its channel in the same cycle, together with its burst count.

When there is no room, ready drops in the same cycle and a pending-retry flag is raised for that channel and direction. The flag stays set until the channel reports that it has freed space in that queue. At that point the flag clears and a single-cycle retry pulse goes upstream. Read capacity also counts the responses still waiting in the channel's return path.

Each channel gets half of the combined buffer budget of the two channels. The block also outputs the write-drain high and low watermarks, which are computed from that per-channel write budget.

Top module: `pcar_router`

## Requirements
- R1: Address bit CH_BIT (default 6) selects the channel: 0 routes to channel 0 and 1 routes to channel 1.
- R2: push_bursts_o equals ceil(((addr mod BURST_BYTES) + size) / BURST_BYTES), where BURST_BYTES is a power of two (default 32).
- R3: A write is refused (req_ready_o low in the same cycle, no push) when the channel's write occupancy plus its bursts exceeds WR_LIMIT = (CH0_WR_BUF + CH1_WR_BUF) / 2 (default 64). Equality is admitted.
- R4: A read is refused when the channel's read occupancy plus its pending responses plus its bursts exceeds RD_LIMIT = (CH0_RD_BUF + CH1_RD_BUF) / 2 (default 32). Equality is admitted.
- R5: An admitted valid request holds req_ready_o high and raises exactly one push_valid_o bit, the target channel's bit, in the same cycle. push_write_o, push_addr_o and push_bursts_o carry the request.
- R6: A refused valid request sets retry_pend_o[2*ch + dir] from the next cycle on, where dir is 1 for a write and 0 for a read.
- R7: A set flag clears when free_wr_i[ch] (writes) or free_rd_i[ch] (reads) is high at a clock edge, unless a new refusal sets it at that same edge. retry_o is high for exactly the following cycle. A free pulse on a clear flag has no effect.
- R8: A valid read of size 0 is consumed (req_ready_o high) but not pushed. err_o then stays high from the next cycle until reset.
- R9: wr_hi_mark_o = floor(WR_LIMIT * WR_HI_PCT / 100) and wr_lo_mark_o = floor(WR_LIMIT * WR_LO_PCT / 100). With the defaults (85 and 50 percent) these are 54 and 32.
- R10: While reset is asserted, retry_pend_o, retry_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted, low when refused |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | SIZE_W | Byte size |
| rd_occ_i | input | 2*OCC_W | Read-queue occupancy, channel c at bits [c*OCC_W +: OCC_W] |
| rsp_occ_i | input | 2*OCC_W | Pending responses per channel, same packing |
| wr_occ_i | input | 2*OCC_W | Write-queue occupancy per channel, same packing |
| free_rd_i | input | 2 | Per-channel read-queue space freed |
| free_wr_i | input | 2 | Per-channel write-queue space freed |
| push_valid_o | output | 2 | Per-channel push strobe |
| push_write_o | output | 1 | Direction of pushed request |
| push_addr_o | output | ADDR_W | Address of pushed request |
| push_bursts_o | output | BCNT_W | Burst count of pushed request |
| retry_pend_o | output | 4 | Pending retry flags, index 2*ch + dir |
| retry_o | output | 1 | One-cycle retry pulse to upstream |
| err_o | output | 1 | Sticky zero-size-read error |
| wr_hi_mark_o | output | OCC_W | Write-drain high watermark |
| wr_lo_mark_o | output | OCC_W | Write-drain low watermark |

## Verification
Ready, the push strobes and the push payload are combinational, so they must be correct in the same cycle the request is presented. The bench drives inputs on the falling edge and samples these outputs 1 ns later. The retry flags, the retry pulse and the error flag each pass through one register, so they change on the next rising edge. The bench checks them at the following falling edge, before it drives new inputs, against a model state that it advanced from the previous stimulus.

// File: rtl/pcar_pkg.sv
package pcar_pkg;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned NUM_SLOT = 2 * NUM_CH;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } pcar_dir_e;

  function automatic int unsigned slot_idx(input int unsigned ch, input logic wr);
    return ch * 2 + (wr ? 1 : 0);
  endfunction
endpackage

// File: rtl/pcar_burst_calc.sv
module pcar_burst_calc #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SIZE_W      = 8,
  parameter int unsigned BURST_BYTES = 32,
  parameter int unsigned BCNT_W      = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [BCNT_W-1:0] bursts_o
);
  localparam int unsigned OFF_W = $clog2(BURST_BYTES);

  logic [BCNT_W-1:0] off;
  logic [BCNT_W-1:0] span;

  assign off      = BCNT_W'(addr_i[OFF_W-1:0]);
  // ceil via add of (BURST_BYTES-1) then shift
  assign span     = off + BCNT_W'(size_i) + BCNT_W'(BURST_BYTES - 1);
  assign bursts_o = span >> OFF_W;
endmodule

// File: rtl/pcar_cap_check.sv
module pcar_cap_check #(
  parameter int unsigned OCC_W    = 8,
  parameter int unsigned BCNT_W   = 10,
  parameter int unsigned RD_LIMIT = 32,
  parameter int unsigned WR_LIMIT = 64
) (
  input  logic [OCC_W-1:0]  rd_occ_i,
  input  logic [OCC_W-1:0]  rsp_occ_i,
  input  logic [OCC_W-1:0]  wr_occ_i,
  input  logic [BCNT_W-1:0] bursts_i,
  output logic              rd_over_o,
  output logic              wr_over_o
);
  localparam int unsigned CW = ((OCC_W > BCNT_W) ? OCC_W : BCNT_W) + 2;

  logic [CW-1:0] rd_need;
  logic [CW-1:0] wr_need;

  assign rd_need   = CW'(rd_occ_i) + CW'(rsp_occ_i) + CW'(bursts_i);
  assign wr_need   = CW'(wr_occ_i) + CW'(bursts_i);
  assign rd_over_o = rd_need > CW'(RD_LIMIT);
  assign wr_over_o = wr_need > CW'(WR_LIMIT);
endmodule

// File: rtl/pcar_retry_track.sv
module pcar_retry_track #(
  parameter int unsigned NUM_SLOT = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SLOT-1:0] set_i,
  input  logic [NUM_SLOT-1:0] free_i,
  output logic [NUM_SLOT-1:0] pend_o,
  output logic                retry_o
);
  logic [NUM_SLOT-1:0] pend_q;
  logic [NUM_SLOT-1:0] clr;
  logic                retry_q;

  assign clr = pend_q & free_i & ~set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      retry_q <= 1'b0;
    end else begin
      pend_q  <= set_i | (pend_q & ~free_i);
      retry_q <= |clr;
    end
  end

  assign pend_o  = pend_q;
  assign retry_o = retry_q;

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_chk
    a_r6_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> pend_o[k]);
    a_r7_flag_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[k] && free_i[k] && !set_i[k]) |=> (retry_o && !pend_o[k]));
  end

  a_r7_retry_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o == '0) |=> !retry_o);
endmodule

// File: rtl/pcar_router.sv
module pcar_router
  import pcar_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SIZE_W      = 8,
  parameter int unsigned OCC_W       = 8,
  parameter int unsigned BURST_BYTES = 32,
  parameter int unsigned CH_BIT      = 6,
  parameter int unsigned CH0_RD_BUF  = 32,
  parameter int unsigned CH1_RD_BUF  = 32,
  parameter int unsigned CH0_WR_BUF  = 64,
  parameter int unsigned CH1_WR_BUF  = 64,
  parameter int unsigned WR_HI_PCT   = 85,
  parameter int unsigned WR_LO_PCT   = 50,
  localparam int unsigned OFF_W      = $clog2(BURST_BYTES),
  localparam int unsigned BCNT_W     = ((SIZE_W > OFF_W) ? SIZE_W : OFF_W) + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_write_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [SIZE_W-1:0]       req_size_i,
  input  logic [2*OCC_W-1:0]      rd_occ_i,
  input  logic [2*OCC_W-1:0]      rsp_occ_i,
  input  logic [2*OCC_W-1:0]      wr_occ_i,
  input  logic [1:0]              free_rd_i,
  input  logic [1:0]              free_wr_i,
  output logic [1:0]              push_valid_o,
  output logic                    push_write_o,
  output logic [ADDR_W-1:0]       push_addr_o,
  output logic [BCNT_W-1:0]       push_bursts_o,
  output logic [3:0]              retry_pend_o,
  output logic                    retry_o,
  output logic                    err_o,
  output logic [OCC_W-1:0]        wr_hi_mark_o,
  output logic [OCC_W-1:0]        wr_lo_mark_o
);
  localparam int unsigned RD_LIMIT = (CH0_RD_BUF + CH1_RD_BUF) / 2;
  localparam int unsigned WR_LIMIT = (CH0_WR_BUF + CH1_WR_BUF) / 2;
  localparam int unsigned WR_HI    = (WR_LIMIT * WR_HI_PCT) / 100;
  localparam int unsigned WR_LO    = (WR_LIMIT * WR_LO_PCT) / 100;
  localparam int unsigned CW       = ((OCC_W > BCNT_W) ? OCC_W : BCNT_W) + 2;

  logic [BCNT_W-1:0]   bursts;
  logic [NUM_CH-1:0]   rd_over;
  logic [NUM_CH-1:0]   wr_over;
  logic                ch_sel;
  pcar_dir_e           dir;
  logic                zero_rd;
  logic                over;
  logic                refuse;
  logic                fire;
  logic [NUM_SLOT-1:0] set_vec;
  logic [NUM_SLOT-1:0] free_vec;
  logic                err_q;

  pcar_burst_calc #(
    .ADDR_W      (ADDR_W),
    .SIZE_W      (SIZE_W),
    .BURST_BYTES (BURST_BYTES),
    .BCNT_W      (BCNT_W)
  ) u_burst (
    .addr_i   (req_addr_i),
    .size_i   (req_size_i),
    .bursts_o (bursts)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pcar_cap_check #(
      .OCC_W    (OCC_W),
      .BCNT_W   (BCNT_W),
      .RD_LIMIT (RD_LIMIT),
      .WR_LIMIT (WR_LIMIT)
    ) u_cap (
      .rd_occ_i  (rd_occ_i[c*OCC_W +: OCC_W]),
      .rsp_occ_i (rsp_occ_i[c*OCC_W +: OCC_W]),
      .wr_occ_i  (wr_occ_i[c*OCC_W +: OCC_W]),
      .bursts_i  (bursts),
      .rd_over_o (rd_over[c]),
      .wr_over_o (wr_over[c])
    );

    assign push_valid_o[c]                 = fire && (ch_sel == 1'(c));
    assign free_vec[slot_idx(c, DIR_RD)]   = free_rd_i[c];
    assign free_vec[slot_idx(c, DIR_WR)]   = free_wr_i[c];

    a_r3_wr_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_valid_o[c] && push_write_o) |->
        (CW'(wr_occ_i[c*OCC_W +: OCC_W]) + CW'(push_bursts_o) <= CW'(WR_LIMIT)));
    a_r4_rd_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_valid_o[c] && !push_write_o) |->
        (CW'(rd_occ_i[c*OCC_W +: OCC_W]) + CW'(rsp_occ_i[c*OCC_W +: OCC_W])
         + CW'(push_bursts_o) <= CW'(RD_LIMIT)));
  end

  assign ch_sel  = req_addr_i[CH_BIT];
  assign dir     = req_write_i ? DIR_WR : DIR_RD;
  assign zero_rd = (dir == DIR_RD) && (req_size_i == '0);
  assign over    = (dir == DIR_WR) ? wr_over[ch_sel] : rd_over[ch_sel];
  assign refuse  = over && !zero_rd;
  assign fire    = req_valid_i && !refuse && !zero_rd;

  assign req_ready_o   = !refuse;
  assign push_write_o  = req_write_i;
  assign push_addr_o   = req_addr_i;
  assign push_bursts_o = bursts;

  always_comb begin
    set_vec = '0;
    set_vec[slot_idx(int'(ch_sel), req_write_i)] = req_valid_i && refuse;
  end

  pcar_retry_track #(
    .NUM_SLOT (NUM_SLOT)
  ) u_retry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .free_i  (free_vec),
    .pend_o  (retry_pend_o),
    .retry_o (retry_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      err_q <= 1'b0;
    else if (req_valid_i && zero_rd)  err_q <= 1'b1;
  end

  assign err_o        = err_q;
  assign wr_hi_mark_o = OCC_W'(WR_HI);
  assign wr_lo_mark_o = OCC_W'(WR_LO);

  a_r5_push_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push_valid_o));
  a_r1_route_ch1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_valid_o[1] |-> req_addr_i[CH_BIT]);
  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r8_zero_rd_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_size_i == '0) |=> err_o);
endmodule

// File: tb/pcar_router_tb.sv
`timescale 1ns/1ps
module pcar_router_tb_top;
  localparam int OCC_W  = 8;
  localparam int BCNT_W = 10;
  localparam int BB     = 32;
  localparam int RD_LIM = 32;
  localparam int WR_LIM = 64;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic              req_write_i = 1'b0;
  logic [31:0]       req_addr_i = '0;
  logic [7:0]        req_size_i = '0;
  logic [2*OCC_W-1:0] rd_occ_i = '0, rsp_occ_i = '0, wr_occ_i = '0;
  logic [1:0]        free_rd_i = '0, free_wr_i = '0;
  logic [1:0]        push_valid_o;
  logic              push_write_o;
  logic [31:0]       push_addr_o;
  logic [BCNT_W-1:0] push_bursts_o;
  logic [3:0]        retry_pend_o;
  logic              retry_o, err_o;
  logic [OCC_W-1:0]  wr_hi_mark_o, wr_lo_mark_o;

  pcar_router dut_i (.*);

  always #10 clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [3:0] m_pend = '0;
  logic m_retry = 1'b0, m_err = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_bursts(input logic [31:0] a, input int sz);
    return ((a % BB) + sz + BB - 1) / BB;
  endfunction

  task automatic check_regs();
    chk("R6 retry_pend", int'(retry_pend_o), int'(m_pend));
    chk("R7 retry pulse", int'(retry_o), int'(m_retry));
    chk("R8 err sticky", int'(err_o), int'(m_err));
  endtask

  task automatic cycle(input bit v, input bit wr, input logic [31:0] a, input int sz,
                       input int rdo0, input int rdo1, input int rsp0, input int rsp1,
                       input int wro0, input int wro1, input logic [1:0] frd,
                       input logic [1:0] fwr);
    int ch, b, need, lim, slot;
    bit zr, ref_, fire;
    logic [3:0] setv, fv;
    @(negedge clk_i);
    check_regs();
    req_valid_i = v; req_write_i = wr; req_addr_i = a; req_size_i = 8'(sz);
    rd_occ_i = {8'(rdo1), 8'(rdo0)}; rsp_occ_i = {8'(rsp1), 8'(rsp0)};
    wr_occ_i = {8'(wro1), 8'(wro0)}; free_rd_i = frd; free_wr_i = fwr;
    #1;
    ch = int'(a[6]);
    b  = exp_bursts(a, sz);
    zr = !wr && sz == 0;
    if (wr) begin need = (ch ? wro1 : wro0) + b; lim = WR_LIM; end
    else begin need = (ch ? rdo1 + rsp1 : rdo0 + rsp0) + b; lim = RD_LIM; end
    ref_ = (need > lim) && !zr;
    fire = v && !ref_ && !zr;
    if (v) chk(wr ? "R3 ready" : "R4 ready", int'(req_ready_o), int'(!ref_));
    chk("R5 push_valid", int'(push_valid_o), fire ? (ch ? 2 : 1) : 0);
    if (fire) begin
      chk("R2 bursts", int'(push_bursts_o), b);
      chk("R5 push addr", int'(push_addr_o == a), 1);
      chk("R5 push write", int'(push_write_o), int'(wr));
      chk("R1 channel", int'(push_valid_o[1]), ch);
    end
    slot = ch * 2 + (wr ? 1 : 0);
    setv = '0;
    if (v && ref_) setv[slot] = 1'b1;
    fv = {fwr[1], frd[1], fwr[0], frd[0]};
    m_retry = |(m_pend & fv & ~setv);
    m_pend  = setv | (m_pend & ~fv);
    if (v && zr) m_err = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #5;
    chk("R10 reset pend", int'(retry_pend_o), 0);
    chk("R10 reset retry", int'(retry_o), 0);
    chk("R10 reset err", int'(err_o), 0);
    chk("R9 hi mark", int'(wr_hi_mark_o), (WR_LIM * 85) / 100);
    chk("R9 lo mark", int'(wr_lo_mark_o), (WR_LIM * 50) / 100);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // R3 write boundary: 62 + 2 == 64 admitted, 63 + 2 refused
    cycle(1, 1, 32'h0000_0010, 40, 0, 0, 0, 0, 62, 0, 2'b00, 2'b00);
    cycle(1, 1, 32'h0000_0010, 40, 0, 0, 0, 0, 63, 0, 2'b00, 2'b00);
    // R7: free on ch0 write clears, retry pulse
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b01);
    // R7: free on clear flag has no effect
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b11, 2'b11);
    // R4 read boundary on ch1 (bit 6 set): 20 + 10 + 2 == 32 ok, 21 refused
    cycle(1, 0, 32'h0000_0050, 48, 0, 20, 0, 10, 0, 0, 2'b00, 2'b00);
    cycle(1, 0, 32'h0000_0050, 48, 0, 21, 0, 10, 0, 0, 2'b00, 2'b00);
    // R7: refusal and free same edge keeps flag set
    cycle(1, 0, 32'h0000_0050, 48, 0, 21, 0, 10, 0, 0, 2'b10, 2'b00);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b10, 2'b00);
    // R8 zero-size read consumed, not pushed, even when full
    cycle(1, 0, 32'h0000_0000, 0, 40, 0, 0, 0, 0, 0, 2'b00, 2'b00);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
    // R2 largest span: offset 31 + 255 -> 9 bursts
    cycle(1, 1, 32'h0000_001F, 255, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
    for (int i = 0; i < 3000; i++) begin
      cycle($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom,
            $urandom_range(1, 255),
            $urandom_range(0, 31), $urandom_range(0, 31),
            $urandom_range(0, 15), $urandom_range(0, 15),
            $urandom_range(0, 70), $urandom_range(0, 70),
            2'($urandom_range(0, 3) & $urandom_range(0, 3)),
            2'($urandom_range(0, 3) & $urandom_range(0, 3)));
    end
    @(negedge clk_i);
    check_regs();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule